// File: doc/BRIEF.md
# Per-Flow Rule Engine

The engine processes packets that arrive as beats marked with valid, start and end flags. Each packet belongs to a flow, and each flow owns one context record in a small on-chip store. When a packet begins, the engine fetches that flow's record into working registers. Each accepted beat carries an event code. Every beat is tested in parallel against a programmable table of eight rules. The single winning rule rewrites one context field, drives the two shared counters and can fold the beat's data word into a ones'-complement checksum. When the packet ends, the working record is stored back and shown for one cycle on a write-back port.

Rules are loaded through a write port while traffic runs. When several rules fire on the same beat, the lowest-numbered rule wins. A beat that matches no rule leaves the record untouched and raises a miss pulse. A packet that starts right after a packet of the same flow takes the record straight from the working registers. It therefore never reads an entry that is still being stored.

Top module: `flow_rule_engine`

## Requirements
- R1: After reset the engine holds `in_ready`, `wb_valid`, `ev_done` and `ev_miss` low, and every flow's stored context reads as all zeros.
- R2: A start beat waits two cycles with `in_ready` low while the context loads. It is accepted on the third clock edge. The clock edge that accepts an end beat is followed by exactly one cycle in which `wb_valid` is high, `in_ready` is low, `wb_flow` is the packet's flow and `wb_ctx` is the record.
- R3: `wb_ctx` packs, from MSB down, the 16-bit checksum, counter 1 (8 bits), counter 0 (8 bits), then fields 3, 2, 1, 0 (8 bits each). A flow's record survives other flows' packets and is reloaded when that flow's next packet starts.
- R4: A start beat for the same flow presented during the write-back cycle continues from the record just written, not from a stale store entry.
- R5: `cfg_rule` packs, from MSB down: enable(1), event(4), condition field select(2), mask(8), compare(8), write enable(1), write field select(2), write value(8), counter 1 op(2), counter 0 op(2), checksum add(1). A rule hits when it is enabled, its event equals `in_evt`, and the selected field ANDed with the mask equals the compare value.
- R6: When several rules hit, only the one with the lowest index acts.
- R7: A beat that hits no rule leaves the context unchanged and sets `ev_miss` for the one cycle after it. A disabled rule never hits.
- R8: Counter op codes are 0 hold, 1 step, 2 clear and 3 load from `in_data[7:0]`. Counter 0 steps up and saturates at 255. Counter 1 steps down and rolls from 0 to 255.
- R9: The checksum add forms the 16-bit ones'-complement sum of the checksum and `in_data`, with the end-around carry added back in.
- R10: One cycle after each accepted beat, `ev_done` is high and `ev_rule` gives the index of the winning rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Rule table write strobe |
| cfg_idx | input | 3 | Rule slot to write |
| cfg_rule | input | 39 | Packed rule |
| in_valid | input | 1 | Beat valid |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_flow | input | 4 | Flow index, sampled with the start beat |
| in_evt | input | 4 | Event code of the beat |
| in_data | input | 16 | Beat data word |
| in_ready | output | 1 | Beat accepted on this edge when valid |
| ev_done | output | 1 | A beat was processed in the previous cycle |
| ev_rule | output | 3 | Winning rule index |
| ev_miss | output | 1 | The previous beat hit no rule |
| wb_valid | output | 1 | Context write-back cycle |
| wb_flow | output | 4 | Flow being written back |
| wb_ctx | output | 64 | Context being written back |

## Verification
On every cycle, the properties check three things. Arbitration grants at most one rule, and that rule is the lowest-indexed hit. A miss leaves the working record intact and never appears without a processed beat. A forwarded load keeps the working record. They also check that an end beat is always followed by a write-back cycle, and that the saturating counter stays at its ceiling. Only the directed packets can show the rule actions themselves, through the stored records: counter wrap and load values, checksum carries, and reload of a flow after other flows have run. The same holds for the stall count on a start beat and for the stale-read case that forwarding avoids.

// File: rtl/fre_pkg.sv
package fre_pkg;
  parameter int EVT_W  = 4;
  parameter int FLD_W  = 8;
  parameter int NFLD   = 4;
  parameter int FSEL_W = $clog2(NFLD);
  parameter int NCNT   = 2;
  parameter int CNT_W  = 8;
  parameter int SUM_W  = 16;

  typedef enum logic [1:0] {COP_HOLD, COP_STEP, COP_CLR, COP_LOAD} cop_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_WB} st_e;

  typedef struct packed {
    logic                        en;
    logic [EVT_W-1:0]            evt;
    logic [FSEL_W-1:0]           csel;
    logic [FLD_W-1:0]            mask;
    logic [FLD_W-1:0]            cmp;
    logic                        wen;
    logic [FSEL_W-1:0]           wsel;
    logic [FLD_W-1:0]            wval;
    logic [NCNT-1:0][1:0]        cop;
    logic                        cadd;
  } rule_t;

  typedef struct packed {
    logic [SUM_W-1:0]            sum;
    logic [NCNT-1:0][CNT_W-1:0]  cnt;
    logic [NFLD-1:0][FLD_W-1:0]  fld;
  } ctx_t;

  // ones'-complement sum with end-around carry
  function automatic logic [SUM_W-1:0] oc_add(input logic [SUM_W-1:0] a,
                                              input logic [SUM_W-1:0] b);
    logic [SUM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, s[SUM_W]};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur,
                                                input logic down,
                                                input logic sat);
    if (down) begin
      if (cur == '0) return sat ? '0 : '1;
      return cur - 1'b1;
    end
    if (cur == '1) return sat ? '1 : '0;
    return cur + 1'b1;
  endfunction

  function automatic logic rule_cond(input logic [NFLD-1:0][FLD_W-1:0] fld,
                                     input rule_t r);
    return (fld[r.csel] & r.mask) == r.cmp;
  endfunction
endpackage

// File: rtl/fre_ctx_store.sv
module fre_ctx_store #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem_q[waddr] <= wdata;
      if (re) rdata <= mem_q[raddr];
    end
  end
endmodule

// File: rtl/fre_counter.sv
module fre_counter
  import fre_pkg::*;
#(
  parameter bit DOWN = 1'b0,
  parameter bit SAT  = 1'b1
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] ld,
  output logic [CNT_W-1:0] nxt
);
  always_comb begin
    case (cop_e'(op))
      COP_STEP: nxt = cnt_step(cur, DOWN, SAT);
      COP_CLR:  nxt = '0;
      COP_LOAD: nxt = ld;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/fre_rule_table.sv
module fre_rule_table
  import fre_pkg::*;
#(
  parameter int NR  = 8,
  localparam int IW = $clog2(NR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [IW-1:0]              cfg_idx,
  input  rule_t                      cfg_rule,
  input  logic [EVT_W-1:0]           evt,
  input  logic [NFLD-1:0][FLD_W-1:0] fld,
  output logic [NR-1:0]              hit_vec,
  output logic [NR-1:0]              grant_vec,
  output logic [IW-1:0]              win_idx,
  output rule_t                      win_rule,
  output logic                       any_hit
);
  rule_t tbl_q [NR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) tbl_q[i] <= '0;
    end else if (cfg_we) begin
      tbl_q[cfg_idx] <= cfg_rule;
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_match
    assign hit_vec[r] = tbl_q[r].en && (tbl_q[r].evt == evt) && rule_cond(fld, tbl_q[r]);
  end

  // fixed priority: lowest index wins
  always_comb begin
    grant_vec = '0;
    win_idx   = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        grant_vec    = '0;
        grant_vec[i] = 1'b1;
        win_idx      = IW'(i);
      end
    end
  end

  assign win_rule = tbl_q[win_idx];
  assign any_hit  = |hit_vec;
endmodule

// File: rtl/flow_rule_engine.sv
module flow_rule_engine
  import fre_pkg::*;
#(
  parameter int             NUM_FLOWS = 16,
  parameter int             NUM_RULES = 8,
  parameter logic [NCNT-1:0] CNT_DOWN = 2'b10,
  parameter logic [NCNT-1:0] CNT_SAT  = 2'b01,
  localparam int FW     = $clog2(NUM_FLOWS),
  localparam int IW     = $clog2(NUM_RULES),
  localparam int RULE_W = $bits(rule_t),
  localparam int CTX_W  = $bits(ctx_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [RULE_W-1:0] cfg_rule,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [FW-1:0]     in_flow,
  input  logic [EVT_W-1:0]  in_evt,
  input  logic [SUM_W-1:0]  in_data,
  output logic              in_ready,
  output logic              ev_done,
  output logic [IW-1:0]     ev_rule,
  output logic              ev_miss,
  output logic              wb_valid,
  output logic [FW-1:0]     wb_flow,
  output logic [CTX_W-1:0]  wb_ctx
);
  st_e                st_q;
  logic [FW-1:0]      flow_q;
  logic               fwd_q;
  ctx_t               ctx_q;
  ctx_t               ctx_nxt;
  logic [CTX_W-1:0]   rd_data;

  // named internal events
  logic               beat_fire;
  logic               start_req;
  logic               st_load;
  logic [NUM_RULES-1:0] hit_vec;
  logic [NUM_RULES-1:0] grant_vec;
  logic [IW-1:0]      win_idx;
  rule_t              win_rule;
  logic               any_hit;
  logic [NCNT-1:0][CNT_W-1:0] cnt_nxt;
  logic [CTX_W-1:0]   ctx_bits;
  logic [1:0]         cnt0_op;
  logic [CNT_W-1:0]   cnt0_cur;

  assign in_ready  = (st_q == ST_RUN);
  assign beat_fire = in_valid && in_ready;
  assign start_req = in_valid && in_sop && ((st_q == ST_IDLE) || (st_q == ST_WB));
  assign st_load   = (st_q == ST_LOAD);
  assign ctx_bits  = ctx_q;
  assign cnt0_op   = win_rule.cop[0];
  assign cnt0_cur  = ctx_q.cnt[0];

  fre_ctx_store #(.DEPTH(NUM_FLOWS), .W(CTX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_q == ST_WB),
    .waddr (flow_q),
    .wdata (ctx_bits),
    .re    (start_req),
    .raddr (in_flow),
    .rdata (rd_data)
  );

  fre_rule_table #(.NR(NUM_RULES)) u_rules (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_rule  (rule_t'(cfg_rule)),
    .evt       (in_evt),
    .fld       (ctx_q.fld),
    .hit_vec   (hit_vec),
    .grant_vec (grant_vec),
    .win_idx   (win_idx),
    .win_rule  (win_rule),
    .any_hit   (any_hit)
  );

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    fre_counter #(.DOWN(CNT_DOWN[c]), .SAT(CNT_SAT[c])) u_cnt (
      .cur (ctx_q.cnt[c]),
      .op  (win_rule.cop[c]),
      .ld  (in_data[CNT_W-1:0]),
      .nxt (cnt_nxt[c])
    );
  end

  always_comb begin
    ctx_nxt = ctx_q;
    if (win_rule.wen) ctx_nxt.fld[win_rule.wsel] = win_rule.wval;
    for (int c = 0; c < NCNT; c++) ctx_nxt.cnt[c] = cnt_nxt[c];
    if (win_rule.cadd) ctx_nxt.sum = oc_add(ctx_q.sum, in_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      flow_q  <= '0;
      fwd_q   <= 1'b0;
      ctx_q   <= '0;
      ev_done <= 1'b0;
      ev_rule <= '0;
      ev_miss <= 1'b0;
    end else begin
      ev_done <= beat_fire;
      ev_rule <= win_idx;
      ev_miss <= beat_fire && !any_hit;
      if (start_req) begin
        flow_q <= in_flow;
        fwd_q  <= (st_q == ST_WB) && (in_flow == flow_q);
      end
      case (st_q)
        ST_IDLE: if (start_req) st_q <= ST_LOAD;
        ST_LOAD: begin
          if (!fwd_q) ctx_q <= ctx_t'(rd_data);
          st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (beat_fire && any_hit) ctx_q <= ctx_nxt;
          if (beat_fire && in_eop) st_q <= ST_WB;
        end
        default: st_q <= start_req ? ST_LOAD : ST_IDLE;
      endcase
    end
  end

  assign wb_valid = (st_q == ST_WB);
  assign wb_flow  = flow_q;
  assign wb_ctx   = ctx_bits;
endmodule

// File: rtl/fre_checker.sv
module fre_checker #(
  parameter int NR     = 8,
  parameter int CW     = 64,
  parameter int NW     = 8,
  parameter bit SAT_UP = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_fire,
  input logic          any_hit,
  input logic          in_eop,
  input logic          wb_valid,
  input logic          ev_done,
  input logic          ev_miss,
  input logic          st_load,
  input logic          fwd_q,
  input logic [NR-1:0] hit_vec,
  input logic [NR-1:0] grant_vec,
  input logic [CW-1:0] ctx_bits,
  input logic [1:0]    cnt0_op,
  input logic [NW-1:0] cnt0_cur
);
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_grant_in_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec & ~hit_vec) == '0) && ((hit_vec != '0) == (grant_vec != '0)));

  p_grant_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> (((grant_vec - {{(NR-1){1'b0}}, 1'b1}) & hit_vec) == '0));

  p_miss_has_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |-> ev_done);

  p_miss_keeps_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |-> (ctx_bits == $past(ctx_bits)));

  p_eop_writes_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && in_eop) |=> wb_valid);

  p_forward_keeps_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_load && fwd_q) |=> (ctx_bits == $past(ctx_bits)));

  if (SAT_UP) begin : g_sat
    p_sat_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_fire && any_hit && (cnt0_op == 2'd1) && (cnt0_cur == '1)) |=> (cnt0_cur == '1));
  end
endmodule

bind flow_rule_engine fre_checker #(
  .NR     (NUM_RULES),
  .CW     (CTX_W),
  .NW     (fre_pkg::CNT_W),
  .SAT_UP (CNT_SAT[0] && !CNT_DOWN[0])
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .beat_fire (beat_fire),
  .any_hit   (any_hit),
  .in_eop    (in_eop),
  .wb_valid  (wb_valid),
  .ev_done   (ev_done),
  .ev_miss   (ev_miss),
  .st_load   (st_load),
  .fwd_q     (fwd_q),
  .hit_vec   (hit_vec),
  .grant_vec (grant_vec),
  .ctx_bits  (ctx_bits),
  .cnt0_op   (cnt0_op),
  .cnt0_cur  (cnt0_cur)
);

// File: tb/sim_flow_rule_engine.sv
`timescale 1ns/1ps
module sim_flow_rule_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [38:0] cfg_rule = '0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [3:0]  in_flow = '0, in_evt = '0;
  logic [15:0] in_data = '0;
  logic        in_ready, ev_done, ev_miss, wb_valid;
  logic [2:0]  ev_rule;
  logic [3:0]  wb_flow;
  logic [63:0] wb_ctx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flow_rule_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rule(cfg_rule),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_flow(in_flow),
    .in_evt(in_evt), .in_data(in_data), .in_ready(in_ready), .ev_done(ev_done),
    .ev_rule(ev_rule), .ev_miss(ev_miss), .wb_valid(wb_valid), .wb_flow(wb_flow),
    .wb_ctx(wb_ctx)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum16(input logic [15:0] a, input logic [15:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 65535) s = s - 65535;
    return s[15:0];
  endfunction

  function automatic logic [63:0] pack_ctx(input logic [15:0] sm, input logic [7:0] c1,
      input logic [7:0] c0, input logic [7:0] f3, input logic [7:0] f2,
      input logic [7:0] f1, input logic [7:0] f0);
    return {sm, c1, c0, f3, f2, f1, f0};
  endfunction

  // R5 field order
  function automatic logic [38:0] mk_rule(input bit en, input logic [3:0] evt,
      input logic [1:0] csel, input logic [7:0] mask, input logic [7:0] cmp,
      input bit wen, input logic [1:0] wsel, input logic [7:0] wval,
      input logic [1:0] op1, input logic [1:0] op0, input bit cadd);
    return {en, evt, csel, mask, cmp, wen, wsel, wval, op1, op0, cadd};
  endfunction

  task automatic put_rule(input logic [2:0] idx, input logic [38:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_rule = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one beat at a negedge, returns at the negedge after acceptance
  task automatic beat(input logic [3:0] flow, input logic [3:0] evt, input logic [15:0] data,
                      input bit sop, input bit eop, output int stalls);
    in_valid = 1'b1; in_sop = sop; in_eop = eop;
    in_flow = flow; in_evt = evt; in_data = data;
    stalls = 0;
    while (!in_ready) begin
      @(negedge clk);
      stalls++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic beat_chk(input string req, input logic [3:0] flow, input logic [3:0] evt,
                          input logic [15:0] data, input bit sop, input bit eop,
                          input bit exp_hit, input logic [2:0] exp_rule);
    int st;
    beat(flow, evt, data, sop, eop, st);
    check("R10 done", 64'(ev_done), 64'd1);
    check("R7 miss", 64'(ev_miss), 64'(!exp_hit));
    if (exp_hit) check(req, 64'(ev_rule), 64'(exp_rule));
  endtask

  task automatic wb_chk(input string req, input logic [3:0] flow, input logic [63:0] exp);
    check("R2 wb_valid", 64'(wb_valid), 64'd1);
    check("R2 ready low in write-back", 64'(in_ready), 64'd0);
    check("R2 wb_flow", 64'(wb_flow), 64'(flow));
    check(req, wb_ctx, exp);
  endtask

  task automatic wb_drop_chk();
    @(negedge clk);
    check("R2 wb single cycle", 64'(wb_valid), 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(in_ready), 64'd0);
    check("R1 wb in reset", 64'(wb_valid), 64'd0);
    check("R1 done in reset", 64'(ev_done), 64'd0);
    check("R1 miss in reset", 64'(ev_miss), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready idle", 64'(in_ready), 64'd0);
  endtask

  task automatic t_program();
    put_rule(3'd0, mk_rule(1, 4'd1, 2'd0, 8'hFF, 8'h00, 1, 2'd0, 8'h01, 2'd0, 2'd1, 1));
    put_rule(3'd1, mk_rule(1, 4'd1, 2'd0, 8'h00, 8'h00, 1, 2'd1, 8'hAA, 2'd1, 2'd0, 0));
    put_rule(3'd2, mk_rule(1, 4'd2, 2'd0, 8'h00, 8'h00, 0, 2'd0, 8'h00, 2'd3, 2'd3, 0));
    put_rule(3'd3, mk_rule(1, 4'd3, 2'd0, 8'h00, 8'h00, 0, 2'd0, 8'h00, 2'd0, 2'd0, 1));
    put_rule(3'd4, mk_rule(1, 4'd4, 2'd2, 8'h0F, 8'h05, 1, 2'd3, 8'h77, 2'd0, 2'd0, 0));
    put_rule(3'd5, mk_rule(1, 4'd6, 2'd0, 8'h00, 8'h00, 1, 2'd2, 8'h35, 2'd0, 2'd0, 0));
    put_rule(3'd6, mk_rule(1, 4'd7, 2'd0, 8'h00, 8'h00, 0, 2'd0, 8'h00, 2'd1, 2'd1, 0));
    put_rule(3'd7, mk_rule(0, 4'd5, 2'd0, 8'h00, 8'h00, 1, 2'd0, 8'hEE, 2'd2, 2'd2, 1));
  endtask

  // R6 priority, R9 checksum, R8 roll; R4 back-to-back same flow
  task automatic t_priority_and_forward();
    int st;
    logic [15:0] s;
    beat(4'd3, 4'd1, 16'h1234, 1, 0, st);
    check("R2 load stalls", 64'(st), 64'd2);
    check("R6 rule0 wins", 64'(ev_rule), 64'd0);
    beat_chk("R6 rule1 when rule0 cond false", 4'd3, 4'd1, 16'h0001, 0, 0, 1, 3'd1);
    beat_chk("R5 rule3 event", 4'd3, 4'd3, 16'hFFFF, 0, 1, 1, 3'd3);
    s = sum16(sum16(16'h0, 16'h1234), 16'hFFFF);
    wb_chk("R3 R9 flow3 ctx", 4'd3, pack_ctx(s, 8'hFF, 8'h01, 8'h00, 8'h00, 8'hAA, 8'h01));
    beat(4'd3, 4'd1, 16'h0002, 1, 1, st);
    check("R2 forward stalls", 64'(st), 64'd2);
    check("R4 restored field picks rule1", 64'(ev_rule), 64'd1);
    wb_chk("R4 forwarded ctx", 4'd3, pack_ctx(s, 8'hFE, 8'h01, 8'h00, 8'h00, 8'hAA, 8'h01));
    wb_drop_chk();
  endtask

  // R7 misses and disabled rule, condition on a different field
  task automatic t_miss();
    beat_chk("R7 disabled rule ignored", 4'd5, 4'd5, 16'h4444, 1, 0, 0, 3'd0);
    beat_chk("R5 cond false misses", 4'd5, 4'd4, 16'h0000, 0, 0, 0, 3'd0);
    beat_chk("R5 rule5 write", 4'd5, 4'd6, 16'h0000, 0, 0, 1, 3'd5);
    beat_chk("R5 masked cond true", 4'd5, 4'd4, 16'h0000, 0, 1, 1, 3'd4);
    wb_chk("R5 flow5 ctx", 4'd5, pack_ctx(16'h0, 8'h00, 8'h00, 8'h77, 8'h35, 8'h00, 8'h00));
    wb_drop_chk();
    beat_chk("R7 lone miss", 4'd7, 4'd5, 16'hBEEF, 1, 1, 0, 3'd0);
    wb_chk("R7 R1 untouched zero ctx", 4'd7, 64'h0);
    wb_drop_chk();
  endtask

  // R8 counter variants
  task automatic t_counters();
    beat_chk("R8 load", 4'd9, 4'd2, 16'h00FE, 1, 0, 1, 3'd2);
    beat_chk("R8 step", 4'd9, 4'd7, 16'h0000, 0, 0, 1, 3'd6);
    beat_chk("R8 step", 4'd9, 4'd7, 16'h0000, 0, 1, 1, 3'd6);
    wb_chk("R8 saturate up", 4'd9, pack_ctx(16'h0, 8'hFC, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00));
    wb_drop_chk();
    beat_chk("R8 load", 4'd9, 4'd2, 16'h0001, 1, 0, 1, 3'd2);
    beat_chk("R8 step", 4'd9, 4'd7, 16'h0000, 0, 0, 1, 3'd6);
    beat_chk("R8 step", 4'd9, 4'd7, 16'h0000, 0, 1, 1, 3'd6);
    wb_chk("R8 roll down", 4'd9, pack_ctx(16'h0, 8'hFF, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
    wb_drop_chk();
  endtask

  // R3 reload after other flows, R9 end-around carry
  task automatic t_persist_and_carry();
    logic [15:0] s;
    repeat (2) @(negedge clk);
    beat_chk("R3 reload flow5", 4'd5, 4'd3, 16'h0010, 1, 1, 1, 3'd3);
    wb_chk("R3 flow5 kept fields", 4'd5, pack_ctx(16'h0010, 8'h00, 8'h00, 8'h77, 8'h35, 8'h00, 8'h00));
    wb_drop_chk();
    beat_chk("R9 add", 4'd11, 4'd3, 16'hFFFF, 1, 0, 1, 3'd3);
    beat_chk("R9 add", 4'd11, 4'd3, 16'h0001, 0, 1, 1, 3'd3);
    s = sum16(sum16(16'h0, 16'hFFFF), 16'h0001);
    wb_chk("R9 end-around carry", 4'd11, pack_ctx(s, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00));
    wb_drop_chk();
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_program();
    t_priority_and_forward();
    t_miss();
    t_counters();
    t_persist_and_carry();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule